// File: doc/BRIEF.md
# Parallel Memory Strobe Decoder

This block sits on the device side of a byte-wide parallel nonvolatile memory and turns the host's three active-low strobes into clean internal events. The strobes are chip select, output gate and write strobe. All three, together with the address and data buses, are resampled into the system clock domain through a two-stage synchronizer. The address and data buses travel through a pipeline of the same depth, so every bus sample lines up with the strobe levels that came in with it.

From the synchronized strobes the block decides whether the host is reading or writing. A read drives the data-bus output enable and returns the array or status byte. A write captures the address when the second of chip select and write strobe falls, and the data when the first of them rises. Either strobe may therefore control the write cycle. Each completed write produces a single-cycle strobe to a downstream page loader, carrying the captured address and data. The block also produces a separate pulse on every falling edge of the write strobe, which the page loader uses to time the gap between byte loads.

Every output is registered. A strobe level change on the pins reaches the outputs at the third rising clock edge that samples it: two synchronizer stages and one output register.

Top module: `pmem_strobe_dec`

## Requirements
- R1: While chip select and output gate are both low, `data_oe_o` is 1 and `data_o` carries `rd_data_i`. Both outputs update at the third rising edge after the strobe levels are presented.
- R2: While chip select or output gate is high, `data_oe_o` is 0 and `data_o` is all zeros.
- R3: `rd_addr_o` follows `addr_i` with the same three-edge latency as the strobes.
- R4: A write cycle starts only in the sampled cycle in which chip select and write strobe become both low while output gate is high. If output gate is low in that cycle, no write results from that strobe pair.
- R5: The write address is the `addr_i` value present when the later of the chip-select and write-strobe falling edges is sampled. Address changes after that point do not affect the write.
- R6: The write data is the `data_i` value present when the earlier of the chip-select and write-strobe rising edges is sampled. Data changes after that point do not affect the write.
- R7: Each completed write cycle raises `wr_vld_o` for exactly one clock. `wr_addr_o` and `wr_data_o` hold the captured values from then until the next write.
- R8: If output gate goes low while a write cycle is in progress, the write is abandoned and no `wr_vld_o` pulse is produced for it.
- R9: Every falling edge of the write strobe gives a one-clock `we_fall_o` pulse, whatever the other strobes are doing.
- R10: Synchronous reset clears every output to zero and treats all strobes as inactive (high), so releasing reset produces no edge events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n_i | input | 1 | Chip select strobe, active low, asynchronous |
| oe_n_i | input | 1 | Output gate strobe, active low, asynchronous |
| we_n_i | input | 1 | Write strobe, active low, asynchronous |
| addr_i | input | ADDR_W (13) | Host address bus |
| data_i | input | DATA_W (8) | Host data bus, input side |
| rd_data_i | input | DATA_W (8) | Byte returned by the array or status logic |
| data_o | output | DATA_W (8) | Data bus, output side |
| data_oe_o | output | 1 | Tri-state enable for the data bus driver |
| rd_addr_o | output | ADDR_W (13) | Synchronized address presented to the array for reads |
| wr_vld_o | output | 1 | One-clock strobe for a completed byte write |
| wr_addr_o | output | ADDR_W (13) | Captured write address |
| wr_data_o | output | DATA_W (8) | Captured write data |
| we_fall_o | output | 1 | One-clock pulse on each write-strobe falling edge |

## Verification
The assertions check on every cycle that:
- the bus driver is enabled exactly when the pin strobes, seen three edges earlier, call for a read;
- the output data is zero whenever the driver is off;
- each write pulse is a single cycle and was issued with output gate high;
- each `we_fall_o` pulse matches a real high-to-low step on the write-strobe pin.

The bench's scenarios are needed for the parts that depend on sequence: which address and data value a write captures under write-strobe control and under chip-select control, and that an abandoned write, or a strobe pair that fell while output gate was low, leaves no write behind.

// File: rtl/pmem_pkg.sv
package pmem_pkg;

  // Bit positions inside the synchronized strobe vector
  localparam int STB_CE = 0;
  localparam int STB_OE = 1;
  localparam int STB_WE = 2;
  localparam int STB_N  = 3;

  // Positions inside the write-control strobe pair
  localparam int PAIR_CE = 0;
  localparam int PAIR_WE = 1;

  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_ARMED = 2'd1,
    WS_ABORT = 2'd2
  } wr_state_e;

endpackage

// File: rtl/pmem_sync_chain.sv
module pmem_sync_chain #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= {W{RST_VAL}};
    else     stage[0] <= d_i;
  end

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage[g] <= {W{RST_VAL}};
        else     stage[g] <= stage[g-1];
      end
    end
  endgenerate

  assign q_o = stage[STAGES-1];

endmodule

// File: rtl/pmem_edge_det.sv
module pmem_edge_det #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] fall_o
);

  logic [W-1:0] prev_q;

  // Previous level resets to the inactive (high) state: no edge after reset
  always_ff @(posedge clk) begin
    if (rst) prev_q <= '1;
    else     prev_q <= lvl_i;
  end

  generate
    for (genvar g = 0; g < W; g++) begin : g_fall
      assign fall_o[g] = prev_q[g] & ~lvl_i[g];
    end
  endgenerate

endmodule

// File: rtl/pmem_rd_path.sv
module pmem_rd_path #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n_s,
  input  logic              oe_n_s,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic [ADDR_W-1:0] rd_addr_o
);

  logic rd_act;
  assign rd_act = ~ce_n_s & ~oe_n_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o    <= '0;
      data_oe_o <= 1'b0;
      rd_addr_o <= '0;
    end else begin
      data_oe_o <= rd_act;
      data_o    <= rd_act ? rd_data_i : '0;
      rd_addr_o <= addr_s;
    end
  end

endmodule

// File: rtl/pmem_wr_seq.sv
module pmem_wr_seq
  import pmem_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n_s,
  input  logic              oe_n_s,
  input  logic              we_n_s,
  input  logic [1:0]        pair_fall,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [DATA_W-1:0] data_s,
  output logic              wr_vld_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);

  wr_state_e         state_q;
  logic [ADDR_W-1:0] cap_addr_q;
  logic              both_low;
  logic              pair_start;

  assign both_low   = ~ce_n_s & ~we_n_s;
  // Both low now and one of them just fell: this is the later falling edge
  assign pair_start = both_low & (pair_fall[PAIR_CE] | pair_fall[PAIR_WE]);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= WS_IDLE;
      cap_addr_q <= '0;
      wr_vld_o   <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_vld_o <= 1'b0;
      unique case (state_q)
        WS_IDLE: begin
          if (pair_start && oe_n_s) begin
            state_q    <= WS_ARMED;
            cap_addr_q <= addr_s;
          end
        end
        WS_ARMED: begin
          if (!oe_n_s) begin
            state_q <= WS_ABORT;
          end else if (!both_low) begin
            // First rising edge of the pair: take the data and issue the write
            state_q   <= WS_IDLE;
            wr_vld_o  <= 1'b1;
            wr_addr_o <= cap_addr_q;
            wr_data_o <= data_s;
          end
        end
        WS_ABORT: begin
          if (!both_low) state_q <= WS_IDLE;
        end
        default: state_q <= WS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pmem_strobe_dec.sv
module pmem_strobe_dec
  import pmem_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic              we_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_vld_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              we_fall_o
);

  localparam int BUS_W = ADDR_W + DATA_W;

  logic [STB_N-1:0] stb_raw, stb_s;
  logic [BUS_W-1:0] bus_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s;
  logic [1:0]        pair_lvl, pair_fall;

  assign stb_raw[STB_CE] = ce_n_i;
  assign stb_raw[STB_OE] = oe_n_i;
  assign stb_raw[STB_WE] = we_n_i;

  pmem_sync_chain #(.W(STB_N), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_stb_sync (
    .clk (clk),
    .rst (rst),
    .d_i (stb_raw),
    .q_o (stb_s)
  );

  // Bus pipeline of the same depth keeps samples aligned with the strobes
  pmem_sync_chain #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_bus_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({addr_i, data_i}),
    .q_o (bus_s)
  );

  assign addr_s = bus_s[BUS_W-1:DATA_W];
  assign data_s = bus_s[DATA_W-1:0];

  assign pair_lvl[PAIR_CE] = stb_s[STB_CE];
  assign pair_lvl[PAIR_WE] = stb_s[STB_WE];

  pmem_edge_det #(.W(2)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (pair_lvl),
    .fall_o (pair_fall)
  );

  pmem_rd_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .ce_n_s    (stb_s[STB_CE]),
    .oe_n_s    (stb_s[STB_OE]),
    .addr_s    (addr_s),
    .rd_data_i (rd_data_i),
    .data_o    (data_o),
    .data_oe_o (data_oe_o),
    .rd_addr_o (rd_addr_o)
  );

  pmem_wr_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk       (clk),
    .rst       (rst),
    .ce_n_s    (stb_s[STB_CE]),
    .oe_n_s    (stb_s[STB_OE]),
    .we_n_s    (stb_s[STB_WE]),
    .pair_fall (pair_fall),
    .addr_s    (addr_s),
    .data_s    (data_s),
    .wr_vld_o  (wr_vld_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) we_fall_o <= 1'b0;
    else     we_fall_o <= pair_fall[PAIR_WE];
  end

endmodule

// File: rtl/pmem_strobe_dec_chk.sv
module pmem_strobe_dec_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ce_n_i,
  input logic              oe_n_i,
  input logic              we_n_i,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o,
  input logic              wr_vld_o,
  input logic              we_fall_o
);

  // R1: driver on only if both read strobes were low at the pins
  a_r1_read_drive: assert property (@(posedge clk) disable iff (rst)
    data_oe_o |-> (!$past(ce_n_i, 3) && !$past(oe_n_i, 3)));

  // R2: either read strobe high at the pins keeps the driver off
  a_r2_hiz: assert property (@(posedge clk) disable iff (rst)
    ($past(ce_n_i, 3) || $past(oe_n_i, 3)) |-> !data_oe_o);

  // R2: no stale data while the driver is off
  a_r2_zero_data: assert property (@(posedge clk) disable iff (rst)
    !data_oe_o |-> (data_o == '0));

  // R7: write strobe lasts a single cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    wr_vld_o |=> !wr_vld_o);

  // R8: a write is never issued while output gate was low
  a_r8_no_oe_write: assert property (@(posedge clk) disable iff (rst)
    wr_vld_o |-> $past(oe_n_i, 3));

  // R9: each write-strobe fall pulse matches a high-to-low step at the pin
  a_r9_we_fall: assert property (@(posedge clk) disable iff (rst)
    we_fall_o |-> ($past(we_n_i, 4) && !$past(we_n_i, 3)));

endmodule

bind pmem_strobe_dec pmem_strobe_dec_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ce_n_i    (ce_n_i),
  .oe_n_i    (oe_n_i),
  .we_n_i    (we_n_i),
  .data_o    (data_o),
  .data_oe_o (data_oe_o),
  .wr_vld_o  (wr_vld_o),
  .we_fall_o (we_fall_o)
);

// File: tb/sim_pmem_strobe_dec.sv
`timescale 1ns/1ps
module sim_pmem_strobe_dec;

  localparam int AW = 13;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0, rdat = '0;
  logic [DW-1:0] data_o;
  logic          data_oe_o;
  logic [AW-1:0] rd_addr_o;
  logic          wr_vld_o;
  logic [AW-1:0] wr_addr_o;
  logic [DW-1:0] wr_data_o;
  logic          we_fall_o;

  int n_cmp = 0;
  int n_bad = 0;
  int n_wefall = 0;
  bit finished = 0;
  logic [AW+DW-1:0] wr_log [$];

  always #4 clk = ~clk;

  pmem_strobe_dec #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .ce_n_i(ce_n), .oe_n_i(oe_n), .we_n_i(we_n),
    .addr_i(addr), .data_i(din), .rd_data_i(rdat),
    .data_o(data_o), .data_oe_o(data_oe_o), .rd_addr_o(rd_addr_o),
    .wr_vld_o(wr_vld_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .we_fall_o(we_fall_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: pin history delayed by two samples, then decode
  int  hist_ce[$], hist_oe[$], hist_we[$], hist_ad[$], hist_dt[$];
  int  prev_ce, prev_we, mstate, mcap;
  int  e_oe, e_dat, e_ra, e_wv, e_wa, e_wd, e_wf;

  task automatic model_reset();
    hist_ce = '{1, 1}; hist_oe = '{1, 1}; hist_we = '{1, 1};
    hist_ad = '{0, 0}; hist_dt = '{0, 0};
    prev_ce = 1; prev_we = 1; mstate = 0; mcap = 0;
    e_oe = 0; e_dat = 0; e_ra = 0; e_wv = 0; e_wa = 0; e_wd = 0; e_wf = 0;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      model_reset();
    end else begin
      int c, o, w, a, d;
      c = hist_ce[0]; o = hist_oe[0]; w = hist_we[0]; a = hist_ad[0]; d = hist_dt[0];
      e_oe  = (c == 0 && o == 0);
      e_dat = e_oe ? int'(rdat) : 0;
      e_ra  = a;
      e_wf  = (prev_we == 1 && w == 0);
      e_wv  = 0;
      case (mstate)
        0: if (c == 0 && w == 0 && (prev_ce == 1 || prev_we == 1) && o == 1) begin
             mstate = 1; mcap = a;
           end
        1: if (o == 0) mstate = 2;
           else if (c == 1 || w == 1) begin
             e_wv = 1; e_wa = mcap; e_wd = d; mstate = 0;
           end
        default: if (c == 1 || w == 1) mstate = 0;
      endcase
      prev_ce = c; prev_we = w;
      void'(hist_ce.pop_front()); hist_ce.push_back(int'(ce_n));
      void'(hist_oe.pop_front()); hist_oe.push_back(int'(oe_n));
      void'(hist_we.pop_front()); hist_we.push_back(int'(we_n));
      void'(hist_ad.pop_front()); hist_ad.push_back(int'(addr));
      void'(hist_dt.pop_front()); hist_dt.push_back(int'(din));
    end
    #2;
    if (!rst) begin
      check(data_oe_o == e_oe[0], "R1/R2 data_oe", data_oe_o, e_oe);
      check(data_o == e_dat[DW-1:0], "R1/R2 data_o", data_o, e_dat);
      check(rd_addr_o == e_ra[AW-1:0], "R3 rd_addr", rd_addr_o, e_ra);
      check(wr_vld_o == e_wv[0], "R4/R7/R8 wr_vld", wr_vld_o, e_wv);
      check(wr_addr_o == e_wa[AW-1:0], "R5 wr_addr", wr_addr_o, e_wa);
      check(wr_data_o == e_wd[DW-1:0], "R6 wr_data", wr_data_o, e_wd);
      check(we_fall_o == e_wf[0], "R9 we_fall", we_fall_o, e_wf);
      if (wr_vld_o) wr_log.push_back({wr_addr_o, wr_data_o});
      if (we_fall_o) n_wefall++;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_writes(input string tag, input int n,
                               input logic [AW-1:0] a, input logic [DW-1:0] d);
    check(wr_log.size() == n, {tag, " write count"}, wr_log.size(), n);
    if (n == 1 && wr_log.size() == 1) begin
      check(wr_log[0][AW+DW-1:DW] == a, {tag, " address"}, wr_log[0][AW+DW-1:DW], a);
      check(wr_log[0][DW-1:0] == d, {tag, " data"}, wr_log[0][DW-1:0], d);
    end
    wr_log.delete();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    cyc(5);
    // R10: outputs cleared during reset
    check({data_o, data_oe_o, rd_addr_o, wr_vld_o, wr_addr_o, wr_data_o, we_fall_o} == '0,
          "R10 reset state", int'(data_oe_o), 0);
    rst = 1'b0;
    cyc(4);
    check(n_wefall == 0 && wr_log.size() == 0, "R10 no edge after reset", n_wefall, 0);

    // R1/R3: read
    addr = 13'h0123; rdat = 8'hA5; ce_n = 0; oe_n = 0;
    cyc(6);
    check(data_oe_o == 1 && data_o == 8'hA5, "R1 read drive", data_o, 8'hA5);
    check(rd_addr_o == 13'h0123, "R3 read address", rd_addr_o, 13'h0123);
    oe_n = 1;
    cyc(4);
    check(data_oe_o == 0 && data_o == 0, "R2 hi-z", data_oe_o, 0);
    ce_n = 1;
    cyc(4);

    // R5/R6: write-strobe controlled
    addr = 13'h00AB; ce_n = 0; cyc(3);
    we_n = 0; cyc(3);
    addr = 13'h1FFF; din = 8'h3C; cyc(3);
    we_n = 1; cyc(1);
    din = 8'h99; cyc(3);
    ce_n = 1; cyc(4);
    expect_writes("R5/R6 WE-controlled", 1, 13'h00AB, 8'h3C);
    check(wr_addr_o == 13'h00AB && wr_data_o == 8'h3C, "R7 hold", wr_data_o, 8'h3C);

    // R5/R6: chip-select controlled
    addr = 13'h1234; we_n = 0; cyc(3);
    ce_n = 0; cyc(3);
    addr = 13'h0001; din = 8'h5A; cyc(3);
    ce_n = 1; cyc(1);
    din = 8'h00; cyc(3);
    we_n = 1; cyc(4);
    expect_writes("R5/R6 CE-controlled", 1, 13'h1234, 8'h5A);

    // R8: output gate drops mid-write
    addr = 13'h0777; din = 8'h11; ce_n = 0; we_n = 0; cyc(3);
    oe_n = 0; cyc(3);
    oe_n = 1; cyc(2);
    we_n = 1; ce_n = 1; cyc(4);
    expect_writes("R8 abandoned", 0, '0, '0);

    // R4: strobe pair falls while output gate is low
    oe_n = 0; ce_n = 0; we_n = 0; cyc(3);
    oe_n = 1; cyc(3);
    we_n = 1; cyc(2);
    ce_n = 1; cyc(4);
    expect_writes("R4 gated start", 0, '0, '0);

    // R4/R7: both fall and rise together
    addr = 13'h0A0A; din = 8'hC3; ce_n = 0; we_n = 0; cyc(3);
    ce_n = 1; we_n = 1; cyc(4);
    expect_writes("R7 simultaneous", 1, 13'h0A0A, 8'hC3);

    // R9/R7: three byte loads under one chip select, then a lone write-strobe pulse
    n_wefall = 0;
    ce_n = 0;
    for (int i = 0; i < 3; i++) begin
      addr = AW'(13'h0040 + i); din = DW'(8'h70 + i); we_n = 0; cyc(3);
      we_n = 1; cyc(3);
    end
    ce_n = 1; cyc(3);
    check(wr_log.size() == 3, "R7 page writes", wr_log.size(), 3);
    wr_log.delete();
    we_n = 0; cyc(3);
    we_n = 1; cyc(4);
    check(n_wefall == 4, "R9 we fall count", n_wefall, 4);
    check(wr_log.size() == 0, "R4 no write without chip select", wr_log.size(), 0);

    cyc(4);
    summary();
  end

endmodule